// File: doc/BRIEF.md
# Dual-Function Bus Request Arbiter

This block sits between two internal bus masters, a video engine and an audio engine, and a single PCI request/grant pin pair. It merges the two internal requests into one external REQ#. It then hands the external GNT# to the function that should own the bus. In its plain setting, REQ# is the OR of both requests and the grant is steered by the audio request. Audio has priority, and the grant parks on video when nobody asks.

Two mode inputs adapt it to host bridges that misbehave:

- **Strict-request mode.** Once a grant has been handed to one function, REQ# carries only that function's request. This lasts until the transaction it started has ended and the bus is idle. The other function therefore cannot keep REQ# asserted when the owner drops its request alongside FRAME#.
- **Qualified-grant mode.** A grant is passed inward only while the block is driving REQ#. This gives up bus parking.

GNT#, FRAME# and IRDY# are active-low at the pins. They are resampled on the PCI clock through `PIN_STAGES` flops. REQ# is driven from a flop. Reset is synchronous and active-low. There are no data streams, so there is no valid/ready interface: every port is a plain level signal.

Top module: `dual_req_arbiter`

## Requirements
- R1: While `rst_n` is low, REQ# is driven high and both internal grants are low, whatever GNT# does.
- R2: Outside a strict-mode lock, REQ# is low exactly when either internal request was high one clock earlier.
- R3: With no lock held and no qualification, a grant sampled low on GNT# goes to audio if the audio request is high and otherwise to video. This includes parking on video when neither requests. Grants follow GNT# after `PIN_STAGES` clocks.
- R4: Audio takes the grant even if it raised its request after video did, as long as GNT# had not yet arrived.
- R5: Once a function has received a grant it is locked in as owner. The other function gets no grant until the lock is released.
- R6: In strict mode, while locked, REQ# reflects only the owner's request. When the owner drops its request, REQ# goes high one clock later even if the other function is requesting.
- R7: The lock is released when, after FRAME# was seen low, the sampled FRAME# and IRDY# are both high. It is also released when GNT# is withdrawn before any FRAME#. After release, the merged OR returns to REQ#.
- R8: In qualified-grant mode, no internal grant is given while REQ# is high. In particular there is no parking grant when neither function requests.
- R9: At most one internal grant is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_req_i | input | 1 | Video function bus request, active-high |
| aud_req_i | input | 1 | Audio function bus request, active-high |
| vid_gnt_o | output | 1 | Grant to video function, active-high |
| aud_gnt_o | output | 1 | Grant to audio function, active-high |
| req_n_o | output | 1 | External request pin, active-low |
| gnt_n_i | input | 1 | External grant pin, active-low |
| frame_n_i | input | 1 | Bus FRAME# pin, active-low |
| irdy_n_i | input | 1 | Bus IRDY# pin, active-low |
| strict_mode_i | input | 1 | Enables request lock (strict-request mode) |
| qual_mode_i | input | 1 | Enables qualified-grant mode |

## Verification
The bench builds the block with the default `PIN_STAGES = 1`. With one resample stage, every pin-to-output delay is a single clock, so expected values follow directly from the sequence of driven pins.

In this configuration a full sweep is possible over both mode bits and both request inputs, with a grant pulse in each of the sixteen cases. Directed sequences cover the following:

- a late audio request arriving before the grant;
- an owner dropping its request as FRAME# falls while the other function keeps requesting, in both modes;
- a grant withdrawn before any transaction starts.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {OWN_VID = 1'b0, OWN_AUD = 1'b1} owner_e;
  localparam int unsigned PIN_W = 3;
  localparam int unsigned IDX_GNT = 0;
  localparam int unsigned IDX_FRAME = 1;
  localparam int unsigned IDX_IRDY = 2;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lock_ctl.sv
module lock_ctl
  import arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   vid_gnt_i,
  input  logic   aud_gnt_i,
  input  logic   gnt_q_i,
  input  logic   frame_q_i,
  input  logic   irdy_q_i,
  output logic   locked_o,
  output owner_e owner_o
);
  logic seen_frame;
  logic release_now;

  // bus idle after a transaction, or grant pulled before one began
  assign release_now = locked_o && !frame_q_i && !irdy_q_i
                       && (seen_frame || !gnt_q_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_o   <= 1'b0;
      owner_o    <= OWN_VID;
      seen_frame <= 1'b0;
    end else if (release_now) begin
      locked_o   <= 1'b0;
      seen_frame <= 1'b0;
    end else if (locked_o) begin
      seen_frame <= seen_frame | frame_q_i;
    end else if (vid_gnt_i || aud_gnt_i) begin
      locked_o   <= 1'b1;
      owner_o    <= aud_gnt_i ? OWN_AUD : OWN_VID;
      seen_frame <= 1'b0;
    end
  end

  a_r5_owner_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !release_now) |=> (locked_o && $stable(owner_o)));

  a_r7_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && seen_frame && !frame_q_i && !irdy_q_i) |=> !locked_o);
endmodule

// File: rtl/req_merge.sv
module req_merge
  import arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   vid_req_i,
  input  logic   aud_req_i,
  input  logic   strict_i,
  input  logic   locked_i,
  input  owner_e owner_i,
  output logic   req_q_o
);
  logic req_d;
  logic owner_req;

  assign owner_req = (owner_i == OWN_AUD) ? aud_req_i : vid_req_i;
  assign req_d     = (strict_i && locked_i) ? owner_req
                                            : (vid_req_i | aud_req_i);

  always_ff @(posedge clk) begin
    if (!rst_n) req_q_o <= 1'b0;
    else        req_q_o <= req_d;
  end

  a_r6_other_cannot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (strict_i && locked_i && owner_i == OWN_VID && !vid_req_i) |=> !req_q_o);

  a_r2_any_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_i && (vid_req_i || aud_req_i)) |=> req_q_o);
endmodule

// File: rtl/grant_steer.sv
module grant_steer
  import arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   gnt_q_i,
  input  logic   aud_req_i,
  input  logic   qual_i,
  input  logic   req_q_i,
  input  logic   locked_i,
  input  owner_e owner_i,
  output logic   vid_gnt_o,
  output logic   aud_gnt_o
);
  logic pick_aud;
  logic pass;

  assign pick_aud  = locked_i ? (owner_i == OWN_AUD) : aud_req_i;
  assign pass      = gnt_q_i && (!qual_i || req_q_i);
  assign vid_gnt_o = pass && !pick_aud;
  assign aud_gnt_o = pass &&  pick_aud;

  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vid_gnt_o, aud_gnt_o}));

  a_r8_no_grant_unrequested: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_i && !req_q_i) |-> !(vid_gnt_o || aud_gnt_o));

  a_r5_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_i && owner_i == OWN_VID) |-> !aud_gnt_o);
endmodule

// File: rtl/dual_req_arbiter.sv
module dual_req_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned PIN_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vid_req_i,
  input  logic aud_req_i,
  output logic vid_gnt_o,
  output logic aud_gnt_o,
  output logic req_n_o,
  input  logic gnt_n_i,
  input  logic frame_n_i,
  input  logic irdy_n_i,
  input  logic strict_mode_i,
  input  logic qual_mode_i
);
  logic [PIN_W-1:0] pins_hi;
  logic [PIN_W-1:0] pins_q;
  logic   locked;
  owner_e owner;
  logic   req_q;

  assign pins_hi[IDX_GNT]   = ~gnt_n_i;
  assign pins_hi[IDX_FRAME] = ~frame_n_i;
  assign pins_hi[IDX_IRDY]  = ~irdy_n_i;

  pin_sync #(.W(PIN_W), .STAGES(PIN_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_hi), .q_o(pins_q)
  );

  lock_ctl u_lock (
    .clk(clk), .rst_n(rst_n),
    .vid_gnt_i(vid_gnt_o), .aud_gnt_i(aud_gnt_o),
    .gnt_q_i(pins_q[IDX_GNT]), .frame_q_i(pins_q[IDX_FRAME]),
    .irdy_q_i(pins_q[IDX_IRDY]),
    .locked_o(locked), .owner_o(owner)
  );

  req_merge u_req (
    .clk(clk), .rst_n(rst_n),
    .vid_req_i(vid_req_i), .aud_req_i(aud_req_i),
    .strict_i(strict_mode_i), .locked_i(locked), .owner_i(owner),
    .req_q_o(req_q)
  );

  grant_steer u_gnt (
    .clk(clk), .rst_n(rst_n),
    .gnt_q_i(pins_q[IDX_GNT]), .aud_req_i(aud_req_i),
    .qual_i(qual_mode_i), .req_q_i(req_q),
    .locked_i(locked), .owner_i(owner),
    .vid_gnt_o(vid_gnt_o), .aud_gnt_o(aud_gnt_o)
  );

  assign req_n_o = ~req_q;

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (req_n_o && !vid_gnt_o && !aud_gnt_o));
endmodule

// File: tb/sim_dual_req_arbiter.sv
module sim_dual_req_arbiter;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vid_req = 1'b0, aud_req = 1'b0;
  logic gnt_n = 1'b1, frame_n = 1'b1, irdy_n = 1'b1;
  logic strict = 1'b0, qual = 1'b0;
  logic vid_gnt, aud_gnt, req_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_req_arbiter #(.PIN_STAGES(1)) u0 (
    .clk(clk), .rst_n(rst_n), .vid_req_i(vid_req), .aud_req_i(aud_req),
    .vid_gnt_o(vid_gnt), .aud_gnt_o(aud_gnt), .req_n_o(req_n),
    .gnt_n_i(gnt_n), .frame_n_i(frame_n), .irdy_n_i(irdy_n),
    .strict_mode_i(strict), .qual_mode_i(qual)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1: reset holds outputs quiet even with grant and requests active
    gnt_n = 1'b0; vid_req = 1'b1; aud_req = 1'b1;
    tick(); tick(); tick();
    chk("R1 req_n", req_n, 1'b1);
    chk("R1 vid_gnt", vid_gnt, 1'b0);
    chk("R1 aud_gnt", aud_gnt, 1'b0);
    gnt_n = 1'b1; vid_req = 1'b0; aud_req = 1'b0;
    rst_n = 1'b1;
    tick();

    // sweep modes and requests: R2, R3, R8, R9
    for (int s = 0; s < 2; s++) begin
      for (int q = 0; q < 2; q++) begin
        for (int v = 0; v < 2; v++) begin
          for (int a = 0; a < 2; a++) begin
            logic any;
            logic pass;
            strict = s[0]; qual = q[0]; vid_req = v[0]; aud_req = a[0];
            gnt_n = 1'b1;
            any = v[0] | a[0];
            tick(); tick();
            chk("R2 merged req_n", req_n, ~any);
            gnt_n = 1'b0;
            tick();
            pass = !q[0] || any;
            chk(q[0] ? "R8 vid_gnt" : "R3 vid_gnt", vid_gnt, pass && !a[0]);
            chk(q[0] ? "R8 aud_gnt" : "R3 aud_gnt", aud_gnt, pass && a[0]);
            chk("R9 onehot", vid_gnt & aud_gnt, 1'b0);
            gnt_n = 1'b1;
            tick();
            chk("R3 grant drops", vid_gnt | aud_gnt, 1'b0);
          end
        end
      end
    end
    vid_req = 1'b0; aud_req = 1'b0; strict = 1'b0; qual = 1'b0;
    tick(); tick();

    // R4: audio raised after video, before grant
    vid_req = 1'b1;
    tick(); tick();
    aud_req = 1'b1;
    tick();
    gnt_n = 1'b0;
    tick();
    chk("R4 aud_gnt", aud_gnt, 1'b1);
    chk("R4 vid_gnt", vid_gnt, 1'b0);
    gnt_n = 1'b1; vid_req = 1'b0; aud_req = 1'b0;
    tick(); tick(); tick();

    // strict mode transaction: R5, R6, R7
    strict = 1'b1; vid_req = 1'b1;
    tick(); tick();
    gnt_n = 1'b0;
    tick();
    chk("R5 vid granted", vid_gnt, 1'b1);
    tick();
    aud_req = 1'b1;
    tick();
    chk("R5 no preempt vid", vid_gnt, 1'b1);
    chk("R5 no preempt aud", aud_gnt, 1'b0);
    vid_req = 1'b0; frame_n = 1'b0; gnt_n = 1'b1;
    tick();
    chk("R6 req released", req_n, 1'b1);
    tick();
    chk("R6 aud cannot hold", req_n, 1'b1);
    chk("R5 aud still blocked", aud_gnt, 1'b0);
    frame_n = 1'b1; irdy_n = 1'b0;
    tick();
    chk("R7 not idle yet", req_n, 1'b1);
    irdy_n = 1'b1;
    tick();
    chk("R7 lock held until release", req_n, 1'b1);
    tick(); tick();
    chk("R7 merge restored", req_n, 1'b0);
    gnt_n = 1'b0;
    tick();
    chk("R7 aud granted after release", aud_gnt, 1'b1);
    gnt_n = 1'b1; aud_req = 1'b0;
    tick(); tick(); tick();

    // normal mode: other function keeps REQ# low (R2), owner kept (R5)
    strict = 1'b0; vid_req = 1'b1;
    tick(); tick();
    gnt_n = 1'b0;
    tick(); tick();
    aud_req = 1'b1;
    tick();
    chk("R5 normal no preempt", aud_gnt, 1'b0);
    vid_req = 1'b0; frame_n = 1'b0; gnt_n = 1'b1;
    tick(); tick();
    chk("R2 aud holds req in normal", req_n, 1'b0);
    frame_n = 1'b1;
    tick(); tick(); tick();
    aud_req = 1'b0;
    tick(); tick();

    // R7: grant withdrawn before any FRAME# frees the lock
    strict = 1'b1; vid_req = 1'b1;
    tick(); tick();
    gnt_n = 1'b0;
    tick();
    chk("R7 vid first grant", vid_gnt, 1'b1);
    gnt_n = 1'b1;
    tick(); tick();
    aud_req = 1'b1;
    tick();
    gnt_n = 1'b0;
    tick();
    chk("R7 withdraw released aud", aud_gnt, 1'b1);
    chk("R9 withdraw onehot", vid_gnt & aud_gnt, 1'b0);
    gnt_n = 1'b1; vid_req = 1'b0; aud_req = 1'b0;
    tick(); tick(); tick();

    // R8: no parking grant over several cycles
    qual = 1'b1; strict = 1'b0;
    gnt_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R8 no park grant", vid_gnt | aud_gnt, 1'b0);
    end
    gnt_n = 1'b1;
    tick();

    finish_run();
  end
endmodule